// File: doc/BRIEF.md
# Bandwidth-Driven QoS Value Regulator

This block sits on one request path of an interconnect port, with one copy for reads and one for writes. It watches the requests the port accepts and gives each one an effective QoS value. That value falls between a programmed ceiling and a programmed floor. Where it lands depends on how far the requested byte traffic has run past a configured allocation, given in bytes per clock.

An excess counter keeps this record. It drains by the allocation on every clock. It grows by each regulated request's length after that length is rounded up to whole 64-byte granules. The QoS goes down by one level for every step of excess. The step size is a power of two set by a shift code. Only requests that arrive with QoS zero are regulated, and only while regulation is enabled. Every other request keeps the QoS it came in with. Each result appears on a registered output one clock after the request is accepted.

Top module: `qos_bw_regulator`

## Requirements
- R1: `qos_vld` is high exactly one clock after each cycle in which `req_vld` is high, and low otherwise. `qos_out` then carries the value for that request. Synchronous reset drives both outputs to 0.
- R2: While `reg_en` is 0, `qos_out` equals the request's incoming `req_qos`, and the request adds nothing to the excess counter.
- R3: While `reg_en` is 1, a request whose `req_qos` is not zero is given its incoming value unchanged, and it adds nothing to the excess counter.
- R4: A regulated request adds its `req_len` rounded up to the next multiple of 64 bytes. A length of 0 adds 0, 1 adds 64, 64 adds 64 and 65 adds 128.
- R5: On every clock the excess counter first falls by `bw_alloc` (0 to 15 bytes per clock), stopping at zero, and then adds the bytes of a regulated request accepted in that clock.
- R6: A regulated request gets `qos_max - floor(E / 2^step_shift)`, where E is the excess counter value before that request's own bytes are added. The result is never lower than `qos_min`.
- R7: When regulated requests arrive at or below the allocated rate, so that E stays below 2^`step_shift`, each of them gets `qos_max`.
- R8: The excess counter saturates at 2^ACC_W-1 (1,048,575 by default) and never wraps to a small value.
- R9: When `qos_min` is greater than `qos_max`, a regulated request gets `qos_max`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Request accepted this clock |
| req_len | input | LEN_W | Request length in bytes |
| req_qos | input | QOS_W | Incoming QoS of the request |
| reg_en | input | 1 | Regulation enable |
| bw_alloc | input | ALLOC_W | Allocated bytes per clock |
| qos_max | input | QOS_W | QoS given when not over the allocation |
| qos_min | input | QOS_W | Lowest QoS regulation may give |
| step_shift | input | SHIFT_W | Excess bytes per QoS step, as a power of two |
| qos_vld | output | 1 | Result valid, one clock after the request |
| qos_out | output | QOS_W | Effective QoS of that request |

## Verification
Every result is due on the rising edge that follows the edge at which its request was sampled. The bench reads it on the falling edge after that. A model of the excess counter advances on the same edge that samples the request. It computes the expected value from the counter's state before the request's bytes are added and queues that value on the same edge. The monitor pops one expected item for each `qos_vld`, reports any output that has no matching request, and confirms at the end that no expected item is left over.

// File: rtl/qbr_pkg.sv
package qbr_pkg;
  localparam int GRAN_LOG2  = 6;
  localparam int GRAN_BYTES = 1 << GRAN_LOG2;
endpackage

// File: rtl/qbr_granule_round.sv
module qbr_granule_round
  import qbr_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LEN_W-1:0] len_i,
  output logic [LEN_W:0]   bytes_o
);
  localparam logic [LEN_W:0] LOW_MASK = (LEN_W+1)'(GRAN_BYTES - 1);

  logic [LEN_W:0] padded;

  always_comb begin
    padded  = {1'b0, len_i} + LOW_MASK;
    bytes_o = padded & ~LOW_MASK;
  end

  AST_GRANULE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (bytes_o[GRAN_LOG2-1:0] == '0) && ({1'b0, len_i} <= bytes_o) &&
    ((bytes_o - {1'b0, len_i}) < (LEN_W+1)'(GRAN_BYTES))); // R4
endmodule

// File: rtl/qbr_excess_acc.sv
module qbr_excess_acc #(
  parameter int ACC_W   = 20,
  parameter int ALLOC_W = 4,
  parameter int ADD_W   = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ALLOC_W-1:0] alloc_i,
  input  logic               add_vld_i,
  input  logic [ADD_W-1:0]   add_bytes_i,
  output logic [ACC_W-1:0]   acc_o
);
  localparam logic [ACC_W-1:0] ACC_MAX = '1;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;
  logic [ACC_W-1:0] alloc_ext;
  logic [ACC_W-1:0] add_ext;
  logic [ACC_W-1:0] drained;
  logic [ACC_W:0]   sum;

  always_comb begin
    alloc_ext = ACC_W'(alloc_i);
    add_ext   = add_vld_i ? ACC_W'(add_bytes_i) : '0;
    drained   = (acc_q > alloc_ext) ? (acc_q - alloc_ext) : '0;
    sum       = {1'b0, drained} + {1'b0, add_ext};
    acc_d     = sum[ACC_W] ? ACC_MAX : sum[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_d;
  end

  assign acc_o = acc_q;

  AST_DRAIN_NONRISING: assert property (@(posedge clk) disable iff (rst)
    !add_vld_i |=> acc_q <= $past(acc_q)); // R5
  AST_DRAIN_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!add_vld_i && acc_q <= alloc_ext) |=> acc_q == '0); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (add_vld_i && ACC_W'(add_bytes_i) >= alloc_ext) |=> acc_q >= $past(acc_q)); // R8
endmodule

// File: rtl/qbr_qos_map.sv
module qbr_qos_map #(
  parameter int ACC_W   = 20,
  parameter int QOS_W   = 4,
  parameter int SHIFT_W = 5
) (
  input  logic [ACC_W-1:0]   acc_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic [QOS_W-1:0]   max_i,
  input  logic [QOS_W-1:0]   min_i,
  output logic [QOS_W-1:0]   qos_o
);
  logic [ACC_W-1:0] steps;
  logic [QOS_W-1:0] span;
  logic [ACC_W-1:0] span_ext;

  always_comb begin
    steps    = acc_i >> shift_i;
    span     = max_i - min_i;
    span_ext = ACC_W'(span);
    if (min_i > max_i)          qos_o = max_i;
    else if (steps >= span_ext) qos_o = min_i;
    else                        qos_o = max_i - steps[QOS_W-1:0];
  end
endmodule

// File: rtl/qos_bw_regulator.sv
module qos_bw_regulator
  import qbr_pkg::*;
#(
  parameter int  LEN_W   = 12,
  parameter int  QOS_W   = 4,
  parameter int  ALLOC_W = 4,
  parameter int  ACC_W   = 20,
  localparam int SHIFT_W = $clog2(ACC_W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_vld,
  input  logic [LEN_W-1:0]   req_len,
  input  logic [QOS_W-1:0]   req_qos,
  input  logic               reg_en,
  input  logic [ALLOC_W-1:0] bw_alloc,
  input  logic [QOS_W-1:0]   qos_max,
  input  logic [QOS_W-1:0]   qos_min,
  input  logic [SHIFT_W-1:0] step_shift,
  output logic               qos_vld,
  output logic [QOS_W-1:0]   qos_out
);
  logic             regulated;
  logic             add_vld;
  logic [LEN_W:0]   rounded;
  logic [ACC_W-1:0] excess;
  logic [QOS_W-1:0] mapped;

  assign regulated = reg_en && (req_qos == '0);
  assign add_vld   = req_vld && regulated;

  qbr_granule_round #(.LEN_W(LEN_W)) u_round (
    .clk     (clk),
    .rst     (rst),
    .len_i   (req_len),
    .bytes_o (rounded)
  );

  qbr_excess_acc #(.ACC_W(ACC_W), .ALLOC_W(ALLOC_W), .ADD_W(LEN_W + 1)) u_acc (
    .clk         (clk),
    .rst         (rst),
    .alloc_i     (bw_alloc),
    .add_vld_i   (add_vld),
    .add_bytes_i (rounded),
    .acc_o       (excess)
  );

  qbr_qos_map #(.ACC_W(ACC_W), .QOS_W(QOS_W), .SHIFT_W(SHIFT_W)) u_map (
    .acc_i   (excess),
    .shift_i (step_shift),
    .max_i   (qos_max),
    .min_i   (qos_min),
    .qos_o   (mapped)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      qos_vld <= 1'b0;
      qos_out <= '0;
    end else begin
      qos_vld <= req_vld;
      if (req_vld) qos_out <= regulated ? mapped : req_qos;
    end
  end

  AST_VLD_RISE: assert property (@(posedge clk) disable iff (rst)
    req_vld |=> qos_vld); // R1
  AST_VLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !req_vld |=> !qos_vld); // R1
  AST_BYPASS_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (req_vld && !reg_en) |=> qos_out == $past(req_qos)); // R2
  AST_BYPASS_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (req_vld && req_qos != '0) |=> qos_out == $past(req_qos)); // R3
  AST_QOS_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (add_vld && qos_min <= qos_max) |=>
      (qos_out <= $past(qos_max) && qos_out >= $past(qos_min))); // R6
  AST_INVERTED_LIMITS: assert property (@(posedge clk) disable iff (rst)
    (add_vld && qos_min > qos_max) |=> qos_out == $past(qos_max)); // R9
endmodule

// File: tb/qos_bw_regulator_bench.sv
`timescale 1ns/1ps
module qos_bw_regulator_bench;
  localparam int LEN_W   = 12;
  localparam int QOS_W   = 4;
  localparam int ALLOC_W = 4;
  localparam int ACC_W   = 20;
  localparam int SHIFT_W = 5;
  localparam longint ACC_MAX = (longint'(1) << ACC_W) - 1;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               req_vld = 1'b0;
  logic [LEN_W-1:0]   req_len = '0;
  logic [QOS_W-1:0]   req_qos = '0;
  logic               reg_en = 1'b0;
  logic [ALLOC_W-1:0] bw_alloc = '0;
  logic [QOS_W-1:0]   qos_max = 4'd15;
  logic [QOS_W-1:0]   qos_min = '0;
  logic [SHIFT_W-1:0] step_shift = 5'd6;
  logic               qos_vld;
  logic [QOS_W-1:0]   qos_out;

  always #4 clk = ~clk;

  qos_bw_regulator u_qos_bw_regulator (
    .clk(clk), .rst(rst), .req_vld(req_vld), .req_len(req_len),
    .req_qos(req_qos), .reg_en(reg_en), .bw_alloc(bw_alloc),
    .qos_max(qos_max), .qos_min(qos_min), .step_shift(step_shift),
    .qos_vld(qos_vld), .qos_out(qos_out)
  );

  int     n_tests = 0;
  int     n_fail  = 0;
  string  cur_tag = "R1";
  longint macc = 0;
  longint nxt;
  bit     regd;
  int     exp_q[$];
  string  tag_q[$];

  task automatic check(bit ok, string tag, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int map_qos(longint acc, int sh, int mx, int mn);
    longint steps;
    if (mn > mx) return mx;
    steps = acc >> sh;
    if (steps >= longint'(mx - mn)) return mn;
    return mx - int'(steps);
  endfunction

  // Reference model and scoreboard push (R5 drain then add, R8 saturation)
  always @(posedge clk) begin
    if (rst) begin
      macc = 0;
    end else begin
      regd = reg_en && (req_qos == 0);
      if (req_vld) begin
        exp_q.push_back(regd ? map_qos(macc, int'(step_shift), int'(qos_max), int'(qos_min))
                             : int'(req_qos));
        tag_q.push_back(cur_tag);
      end
      nxt = (macc > longint'(bw_alloc)) ? macc - longint'(bw_alloc) : 0;
      if (req_vld && regd) nxt += ((longint'(req_len) + 63) / 64) * 64;
      if (nxt > ACC_MAX) nxt = ACC_MAX;
      macc = nxt;
    end
  end

  // Monitor: results are due one edge after the request (R1)
  always @(negedge clk) begin
    if (!rst && qos_vld) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1", int'(qos_out), -1);
      end else begin
        automatic int    e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(int'(qos_out) == e, t, int'(qos_out), e);
      end
    end
  end

  task automatic send(int len, int q);
    req_vld = 1'b1;
    req_len = LEN_W'(len);
    req_qos = QOS_W'(q);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    req_vld = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(qos_vld == 1'b0 && qos_out == '0, "R1", int'(qos_out), 0);
    rst = 1'b0;
    idle(2);

    cur_tag = "R2";
    reg_en = 1'b0;
    send(64, 0); send(64, 5); send(128, 15);
    idle(2);

    cur_tag = "R3";
    reg_en = 1'b1;
    send(4096, 3); send(4000, 9); send(4096, 1);
    idle(1);
    send(64, 0);
    idle(3);

    cur_tag = "R4";
    bw_alloc = 4'd15; idle(10);
    bw_alloc = 4'd0; step_shift = 5'd6;
    send(1, 0); send(64, 0); send(65, 0); send(0, 0); send(1, 0);
    idle(2);

    cur_tag = "R5";
    bw_alloc = 4'd15; idle(40);
    bw_alloc = 4'd4;
    send(256, 0); idle(10); send(64, 0); idle(30); send(128, 0); send(64, 0);
    idle(20);

    cur_tag = "R7";
    bw_alloc = 4'd15; idle(40);
    bw_alloc = 4'd8;
    for (int i = 0; i < 6; i++) begin
      send(64, 0); idle(7);
    end

    cur_tag = "R6";
    bw_alloc = 4'd2; step_shift = 5'd7; qos_max = 4'd14; qos_min = 4'd8;
    for (int i = 0; i < 12; i++) send(128, 0);
    idle(2);

    cur_tag = "R9";
    qos_max = 4'd3; qos_min = 4'd9;
    send(512, 0); send(512, 0);
    idle(2);

    cur_tag = "R8";
    qos_max = 4'd15; qos_min = 4'd0; step_shift = 5'd16; bw_alloc = 4'd0;
    for (int i = 0; i < 300; i++) send(4095, 0);
    bw_alloc = 4'd15;
    idle(50);
    send(64, 0);
    idle(3);

    check(exp_q.size() == 0, "R1", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R1 watchdog actual=expired expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule